// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire (I2C) slave that serves a byte-wide storage array held in registers inside the block. The bus lines are open-drain. SCL and SDA each come in as a sampled input, and the block pulls SDA low through a single output-enable. A free-running system clock oversamples both lines. A synchronizer and edge detector turn the line activity into SCL rise and fall events and into START and STOP events.

A master selects the device with a 7-bit address. That address is a fixed 4-bit family code (1010) followed by a 3-bit select input, and bit 0 of the same byte picks read (1) or write (0). A write transfer carries one word-address byte and then any number of data bytes. A read transfer returns the byte at the internal pointer, and keeps returning bytes for as long as the master acknowledges. There is only one pointer, and every mode uses it. Writes load and advance it, and reads advance it. It wraps from the top of the array to zero, so the whole array can be read out in one continuous transfer.

Top module: `i2c_ee_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), the pointer is 0 and every array byte reads back as 0x00.
- R2: An address byte whose upper 7 bits equal {1010, `dev_sel`} is acknowledged by pulling SDA low during the ninth SCL pulse. Any other address byte is not acknowledged, and the slave ignores all following bytes until the next START.
- R3: In a write transfer, the first byte after the address is acknowledged and loaded into the pointer.
- R4: Each further byte of a write transfer is acknowledged and stored at the pointer. The pointer then advances by one, wrapping from 255 to 0.
- R5: A read transfer that has no preceding word address returns the byte at the current pointer (a current-address read). The pointer then advances by one.
- R6: A write of the word address, followed by a repeated START and a read address byte, returns the byte at that word address first (a random read).
- R7: While the master acknowledges each byte, the slave sends the next byte, n+1, n+2 and so on. The pointer wraps from 255 to 0 without a break, so all 256 bytes can be read in one transfer.
- R8: After a master not-acknowledge (SDA left high in the ninth clock of a read byte), the slave releases SDA and returns to idle.
- R9: Data goes out MSB first. The slave sets SDA only while SCL is low and samples incoming bits on SCL rising.
- R10: A STOP or a START at any point aborts the current transfer and releases SDA. A word address left incomplete by the abort does not change the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level (wired-AND of all drivers) |
| dev_sel | input | 3 | Low three bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer and therefore a 256-byte array, a two-stage synchronizer, family code 1010, and `dev_sel` tied to 101. With the full 8-bit pointer, the wrap from 255 to 0 can be reached both by writes and by sequential reads. It also makes a single 257-byte read from address 0 possible, which crosses the entire array and lands back on address 0. The SCL quarter period is eight system clocks, which leaves room for the synchronizer latency, so the rule that SDA changes only while SCL is low can be checked on the raw pins.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for START
      ST_DEV,    // shifting in device address
      ST_WADR,   // shifting in word address
      ST_WDAT,   // shifting in write data
      ST_ACK,    // slave drives acknowledge
      ST_TX,     // slave shifts out read data
      ST_MACK    // master acknowledge slot
   } ee_state_t;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_ee_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_q  <= scl_sh[STAGES-1];
         sda_q  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   // R10: bus conditions while SCL stays high
   assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   // R1: array cleared by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (we) begin
         cells[addr] <= wdata;
      end
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/i2c_ee_core.sv
module i2c_ee_core
   import i2c_ee_pkg::*;
#(
   parameter int         AW     = 8,
   parameter logic [3:0] DEV_ID = 4'b1010
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_evt,
   input  logic          stop_evt,
   input  logic [2:0]    dev_sel,
   input  logic [7:0]    rd_data,
   output logic [AW-1:0] ptr,
   output logic          wr_en,
   output logic [7:0]    wr_data,
   output logic          sda_oe,
   output logic          idle
);
   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("i2c_ee_core: AW must lie in 1..8 for a one-byte word address");
      end
   endgenerate

   ee_state_t state, after_ack;
   logic [3:0] bit_cnt;
   logic [7:0] sreg, txreg;
   logic       mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         bit_cnt   <= '0;
         sreg      <= '0;
         txreg     <= '0;
         mack      <= 1'b0;
         ptr       <= '0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
         sda_oe    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         // R4: pointer advances the cycle after a store
         if (wr_en) ptr <= ptr + 1'b1;
         if (start_evt) begin
            // R10: START restarts address reception
            state   <= ST_DEV;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_WADR, ST_WDAT: begin
                  // R9: bits sampled on SCL rising, MSB first
                  if (scl_rise && bit_cnt != 4'd8) begin
                     sreg    <= {sreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (state == ST_DEV) begin
                        // R2: address match check
                        if (sreg[7:1] == {DEV_ID, dev_sel}) begin
                           sda_oe    <= 1'b1;
                           state     <= ST_ACK;
                           after_ack <= sreg[0] ? ST_TX : ST_WADR;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_WADR) begin
                        // R3: word address loads pointer
                        ptr       <= sreg[AW-1:0];
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ST_WDAT;
                     end else begin
                        wr_en     <= 1'b1;
                        wr_data   <= sreg;
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ST_WDAT;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (after_ack == ST_TX) begin
                        // R5: byte at pointer, then pointer + 1
                        txreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 1'b1;
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= after_ack;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                     end else begin
                        bit_cnt <= bit_cnt + 4'd1;
                        txreg   <= {txreg[6:0], 1'b0};
                        sda_oe  <= ~txreg[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  if (scl_fall) begin
                     if (mack) begin
                        // R7: master ACK streams the next byte
                        txreg   <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        ptr     <= ptr + 1'b1;
                        bit_cnt <= '0;
                        state   <= ST_TX;
                     end else begin
                        // R8: NACK ends the read
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign idle = (state == ST_IDLE);
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave #(
   parameter int         AW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_ID      = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] dev_sel,
   output logic       sda_oe
);
   logic          sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic [AW-1:0] ptr;
   logic          wr_en, idle;
   logic [7:0]    wr_data, rd_data;

   i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   i2c_ee_core #(.AW(AW), .DEV_ID(DEV_ID)) u_core (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .dev_sel(dev_sel), .rd_data(rd_data), .ptr(ptr),
      .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe), .idle(idle)
   );

   i2c_ee_mem #(.AW(AW), .DW(8)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(ptr),
      .wdata(wr_data), .rdata(rd_data)
   );
endmodule

// File: rtl/i2c_ee_slave_chk.sv
module i2c_ee_slave_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          sda_oe,
   input logic          stop_evt,
   input logic          wr_en,
   input logic          idle,
   input logic [AW-1:0] ptr
);
   // R9
   oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   // R10
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe);

   // R4
   write_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ptr == $past(ptr) + 1'b1));

   // R8
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !sda_oe);
endmodule

bind i2c_ee_slave i2c_ee_slave_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .stop_evt(stop_evt), .wr_en(wr_en), .idle(idle), .ptr(ptr)
);

// File: tb/i2c_ee_slave_test.sv
module i2c_ee_slave_test;
   localparam int Q = 8;
   localparam logic [7:0] DEVW = 8'hAA;  // 1010 101 0
   localparam logic [7:0] DEVR = 8'hAB;  // 1010 101 1

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_line;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_ee_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .dev_sel(3'b101), .sda_oe(sda_oe)
   );

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;
   logic [7:0] mdl [256];
   logic [7:0] mptr = 8'h00;
   logic [7:0] exp_q[$];
   logic [7:0] act_q[$];
   string      tag_q[$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      while (act_q.size() > 0 && exp_q.size() > 0) begin
         logic [7:0] a, e;
         string t;
         a = act_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(a == e, t, a, e);
      end
   end

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; w(Q);
      scl_m = 1'b1; w(Q);
      sda_m = 1'b0; w(Q);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w(Q);
      scl_m = 1'b1; w(Q);
      sda_m = 1'b1; w(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; w(Q);
         scl_m = 1'b1; w(2*Q);
         scl_m = 1'b0; w(Q);
      end
      sda_m = 1'b1; w(Q);
      scl_m = 1'b1; w(Q);
      ack = !sda_line; w(Q);
      scl_m = 1'b0; w(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit give_ack);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         w(Q);
         scl_m = 1'b1; w(Q);
         b[i] = sda_line; w(Q);
         scl_m = 1'b0; w(Q);
      end
      sda_m = !give_ack; w(Q);
      scl_m = 1'b1; w(2*Q);
      scl_m = 1'b0; w(Q);
      sda_m = 1'b1;
   endtask

   task automatic write_bytes(input logic [7:0] addr, input logic [7:0] d[$]);
      bit ack;
      bus_start();
      send_byte(DEVW, ack);
      check(ack, "R2 address ack", ack, 1);
      send_byte(addr, ack);
      check(ack, "R3 word address ack", ack, 1);
      mptr = addr;
      foreach (d[k]) begin
         send_byte(d[k], ack);
         check(ack, "R4 data ack", ack, 1);
         mdl[mptr] = d[k];
         mptr = mptr + 8'd1;
      end
      bus_stop();
   endtask

   task automatic read_stream(input int n, input string tag);
      logic [7:0] b;
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(mdl[mptr]);
         tag_q.push_back(tag);
         mptr = mptr + 8'd1;
         recv_byte(b, k < n - 1);
         act_q.push_back(b);
      end
      w(Q);
      // R8: released after master NACK
      check(sda_oe == 1'b0, "R8 release after NACK", sda_oe, 0);
      bus_stop();
   endtask

   task automatic cur_read(input int n, input string tag);
      bit ack;
      bus_start();
      send_byte(DEVR, ack);
      check(ack, "R2 read address ack", ack, 1);
      read_stream(n, tag);
   endtask

   task automatic rand_read(input logic [7:0] addr, input int n, input string tag);
      bit ack;
      bus_start();
      send_byte(DEVW, ack);
      check(ack, "R2 address ack", ack, 1);
      send_byte(addr, ack);
      check(ack, "R3 word address ack", ack, 1);
      mptr = addr;
      bus_start();
      send_byte(DEVR, ack);
      check(ack, "R6 repeated start ack", ack, 1);
      read_stream(n, tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      bit ack;
      for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
      w(5);
      // R1: reset state
      check(sda_oe == 1'b0, "R1 SDA released in reset", sda_oe, 0);
      rst_n = 1'b1;
      w(4);
      check(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);

      // R1 R5: current-address read from reset pointer 0
      cur_read(1, "R1 R5 reset pointer read");

      // R3 R4: multi-byte write
      write_bytes(8'h10, '{8'hA5, 8'h5A, 8'hC3});
      // R6: random read
      rand_read(8'h10, 1, "R6 random read");
      // R5: current-address continues at 0x11
      cur_read(2, "R5 current-address read");

      // R4: write wrap 255 -> 0
      write_bytes(8'hFE, '{8'h11, 8'h22, 8'h33});
      // R7 R9: sequential read across the wrap
      rand_read(8'hFD, 5, "R7 R9 sequential wrap read");

      // R2: wrong select is ignored until next START
      bus_start();
      send_byte(8'hA0, ack);
      check(!ack, "R2 mismatch not acked", ack, 0);
      send_byte(8'h20, ack);
      check(!ack, "R2 ignored byte not acked", ack, 0);
      send_byte(8'h99, ack);
      check(!ack, "R2 ignored data not acked", ack, 0);
      bus_stop();
      rand_read(8'h20, 1, "R2 ignored write left array unchanged");

      // R10: STOP in the middle of the word address
      rand_read(8'h10, 1, "R10 setup read");
      bus_start();
      send_byte(DEVW, ack);
      check(ack, "R10 address ack", ack, 1);
      for (int i = 0; i < 4; i++) begin
         sda_m = 1'b0; w(Q);
         scl_m = 1'b1; w(2*Q);
         scl_m = 1'b0; w(Q);
      end
      bus_stop();
      w(Q);
      check(sda_oe == 1'b0, "R10 SDA released after STOP", sda_oe, 0);
      cur_read(1, "R10 pointer unchanged by abort");

      // R7: whole array in one transfer, back to address 0
      rand_read(8'h00, 257, "R7 full array read");

      w(4*Q);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule